// File: doc/BRIEF.md
# Configuration Store Command Sequencer

This block sits behind a byte-wide register port and runs every access to a small non-volatile configuration store. Software loads a store address register and a data register. It then writes a command byte to ask for one of three operations: a single-byte read into the data register, a single-byte write from the data register, or a bulk copy of the mirrored configuration registers into the store. Software must write 0x00 to the command register before each command. This arming write guards against a stray command byte.

Each operation takes a fixed number of clock cycles, and two parameters set those counts: one for a single-byte access and a longer one for the bulk copy. While an operation runs, a busy flag stays high. Software sees the flag both as a status bit and as a pin, and polls it until it drops. A result is visible in the same cycle that busy falls.

The mirror registers are normally reloaded from the store, once after reset and again on every pulse of a refresh strobe. A control bit suspends this reload, so that software can edit the mirrors and copy them into the store without the reload overwriting its edits.

Top module: `ee_cmd_engine`

## Requirements
- R1: Reset starts a reload. Busy is high for exactly BYTE_CYCLES cycles after reset is released. Then the three mirrors at 0x35, 0x36 and 0x37 hold the power-on image of the store, in which byte i is i XOR 0xA5.
- R2: Register 0x25 (store address) and register 0x26 (data) read back the value last written. Status register 0x0E reads busy in bit 7 and zero in its other bits. Control register 0x0F keeps only bit 3 (reload suspend); its other bits read zero.
- R3: A command is taken only when the previous write to register 0x27 was 0x00. A valid code that is not armed in this way is ignored, and busy stays low.
- R4: Command 0x22 holds busy high for exactly BYTE_CYCLES cycles. When busy falls, the data register holds the store byte at the store address.
- R5: Command 0x21 holds busy high for exactly BYTE_CYCLES cycles. It writes the data register into the store byte at the store address.
- R6: Command 0x11 holds busy high for exactly UPDATE_CYCLES cycles. It copies the three mirrors into store bytes 0x35, 0x36 and 0x37.
- R7: A write of any code other than 0x00, 0x11, 0x21 or 0x22 to 0x27 starts nothing. It also disarms the engine, so a valid code written directly after it is ignored as well.
- R8: Commands 0x21 and 0x22 are ignored when the store address is STORE_DEPTH (0x38) or higher.
- R9: While busy is high, writes to 0x25, 0x26, 0x27 and the mirrors are ignored. A 0x00 written to 0x27 during that time does not arm the engine.
- R10: A refresh_tick pulse while the engine is idle with bit 3 of 0x0F clear starts a reload. The reload holds busy high for BYTE_CYCLES cycles and then loads the mirrors from the store. With bit 3 set, the pulse is ignored.
- R11: When an accepted command and a refresh_tick fall in the same cycle, the command runs and the tick is dropped.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset (power-on) |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 8 | Register address, used for writes and reads |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Read data for reg_addr (combinational) |
| refresh_tick | input | 1 | Periodic reload strobe, one cycle wide |
| busy | output | 1 | Store operation in progress |

## Verification
Busy rises in the cycle after the clock edge that takes a command, a tick or a reset release, and stays high for exactly the configured count. The bench drives inputs on falling edges and samples busy once per falling edge, counting the high samples, and compares that count with BYTE_CYCLES or UPDATE_CYCLES. Every data, mirror and store result is read only after busy has been seen low, because the engine applies each result on the same edge that drops busy. Ignored stimuli are checked on the next sample, for busy, and by reading back the registers they could have changed.

// File: rtl/ee_pkg.sv
package ee_pkg;

    // Register-port addresses
    localparam logic [7:0] REG_STATUS  = 8'h0E;
    localparam logic [7:0] REG_CTRL    = 8'h0F;
    localparam logic [7:0] REG_EE_ADDR = 8'h25;
    localparam logic [7:0] REG_EE_DATA = 8'h26;
    localparam logic [7:0] REG_EE_CMD  = 8'h27;

    // Command byte values
    localparam logic [7:0] CMD_ARM    = 8'h00;
    localparam logic [7:0] CMD_UPDATE = 8'h11;
    localparam logic [7:0] CMD_WRITE  = 8'h21;
    localparam logic [7:0] CMD_READ   = 8'h22;

    localparam int BUSY_BIT      = 7;
    localparam int NOREFRESH_BIT = 3;

    typedef enum logic [1:0] {
        OP_READ    = 2'd0,
        OP_WRITE   = 2'd1,
        OP_UPDATE  = 2'd2,
        OP_REFRESH = 2'd3
    } op_e;

endpackage

// File: rtl/ee_cmd_decode.sv
module ee_cmd_decode
    import ee_pkg::*;
(
    input  logic [7:0] cmd_byte,
    input  logic       armed,
    input  logic       addr_ok,
    output logic       accept,
    output op_e        op
);

    always_comb begin
        accept = 1'b0;
        op     = OP_READ;
        case (cmd_byte)
            CMD_UPDATE: begin
                accept = armed;
                op     = OP_UPDATE;
            end
            CMD_WRITE: begin
                accept = armed && addr_ok;
                op     = OP_WRITE;
            end
            CMD_READ: begin
                accept = armed && addr_ok;
                op     = OP_READ;
            end
            default: begin
                accept = 1'b0;
                op     = OP_READ;
            end
        endcase
    end

endmodule

// File: rtl/ee_wait_timer.sv
module ee_wait_timer #(
    parameter int WAIT_W    = 6,
    parameter int RESET_VAL = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [WAIT_W-1:0] load_val,
    output logic              zero
);

    logic [WAIT_W-1:0] count_d, count_q;

    always_comb begin
        count_d = count_q;
        if (load) begin
            count_d = load_val;
        end else if (count_q != '0) begin
            count_d = count_q - 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            count_q <= WAIT_W'(RESET_VAL);
        end else begin
            count_q <= count_d;
        end
    end

    assign zero = (count_q == '0);

    // R4 R6: a load sets the wait length that follows
    a_r4_load_taken: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> (count_q == $past(load_val)));

    // R6: without a load the count moves down by one each cycle
    a_r6_count_down: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && count_q != '0) |=> (count_q == WAIT_W'($past(count_q) - 1'b1)));

endmodule

// File: rtl/ee_store.sv
module ee_store #(
    parameter int          STORE_DEPTH  = 56,
    parameter int          MIRROR_BASE  = 53,
    parameter int          MIRROR_COUNT = 3,
    parameter logic [7:0]  INIT_XOR     = 8'hA5
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic [7:0]                   raddr,
    output logic [7:0]                   rdata,
    input  logic                         we,
    input  logic [7:0]                   waddr,
    input  logic [7:0]                   wdata,
    input  logic                         bulk_we,
    input  logic [MIRROR_COUNT-1:0][7:0] bulk_data,
    output logic [MIRROR_COUNT-1:0][7:0] image
);

    localparam int IDX_W = $clog2(STORE_DEPTH);

    logic [7:0] mem_d [STORE_DEPTH];
    logic [7:0] mem_q [STORE_DEPTH];

    always_comb begin
        for (int i = 0; i < STORE_DEPTH; i++) begin
            mem_d[i] = mem_q[i];
        end
        if (we && (waddr < 8'(STORE_DEPTH))) begin
            mem_d[waddr[IDX_W-1:0]] = wdata;
        end
        if (bulk_we) begin
            for (int i = 0; i < MIRROR_COUNT; i++) begin
                mem_d[MIRROR_BASE + i] = bulk_data[i];
            end
        end
    end

    // Power-on image of the cells: byte i holds i XOR INIT_XOR
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < STORE_DEPTH; i++) begin
                mem_q[i] <= 8'(i) ^ INIT_XOR;
            end
        end else begin
            for (int i = 0; i < STORE_DEPTH; i++) begin
                mem_q[i] <= mem_d[i];
            end
        end
    end

    assign rdata = (raddr < 8'(STORE_DEPTH)) ? mem_q[raddr[IDX_W-1:0]] : 8'h00;

    for (genvar g = 0; g < MIRROR_COUNT; g++) begin : g_image
        assign image[g] = mem_q[MIRROR_BASE + g];
    end

endmodule

// File: rtl/ee_cmd_engine.sv
module ee_cmd_engine
    import ee_pkg::*;
#(
    parameter int BYTE_CYCLES   = 8,
    parameter int UPDATE_CYCLES = 40,
    parameter int STORE_DEPTH   = 56,
    parameter int MIRROR_BASE   = 53,
    parameter int MIRROR_COUNT  = 3
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       reg_we,
    input  logic [7:0] reg_addr,
    input  logic [7:0] reg_wdata,
    output logic [7:0] reg_rdata,
    input  logic       refresh_tick,
    output logic       busy
);

    localparam int MAX_CYCLES = (UPDATE_CYCLES > BYTE_CYCLES) ? UPDATE_CYCLES : BYTE_CYCLES;
    localparam int WAIT_W     = $clog2(MAX_CYCLES + 1);

    typedef struct packed {
        logic                         busy;
        op_e                          op;
        logic [7:0]                   ee_addr;
        logic [7:0]                   ee_data;
        logic                         armed;
        logic                         no_refresh;
        logic [MIRROR_COUNT-1:0][7:0] mirror;
    } state_t;

    state_t d, q;

    logic                         timer_zero;
    logic                         timer_load;
    logic [WAIT_W-1:0]            timer_val;
    logic                         dec_accept;
    op_e                          dec_op;
    logic [7:0]                   store_rdata;
    logic                         store_we;
    logic                         store_bulk_we;
    logic [MIRROR_COUNT-1:0][7:0] store_image;
    logic [7:0]                   mir_idx;
    logic                         mir_hit;
    logic                         idle_wr;

    assign mir_idx = reg_addr - 8'(MIRROR_BASE);
    assign mir_hit = (mir_idx < 8'(MIRROR_COUNT));
    assign idle_wr = reg_we && !q.busy;

    ee_cmd_decode u_decode (
        .cmd_byte (reg_wdata),
        .armed    (q.armed),
        .addr_ok  (q.ee_addr < 8'(STORE_DEPTH)),
        .accept   (dec_accept),
        .op       (dec_op)
    );

    ee_wait_timer #(
        .WAIT_W    (WAIT_W),
        .RESET_VAL (BYTE_CYCLES - 1)
    ) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (timer_load),
        .load_val (timer_val),
        .zero     (timer_zero)
    );

    ee_store #(
        .STORE_DEPTH  (STORE_DEPTH),
        .MIRROR_BASE  (MIRROR_BASE),
        .MIRROR_COUNT (MIRROR_COUNT),
        .INIT_XOR     (8'hA5)
    ) u_store (
        .clk       (clk),
        .rst_n     (rst_n),
        .raddr     (q.ee_addr),
        .rdata     (store_rdata),
        .we        (store_we),
        .waddr     (q.ee_addr),
        .wdata     (q.ee_data),
        .bulk_we   (store_bulk_we),
        .bulk_data (q.mirror),
        .image     (store_image)
    );

    always_comb begin
        d             = q;
        timer_load    = 1'b0;
        timer_val     = WAIT_W'(BYTE_CYCLES - 1);
        store_we      = 1'b0;
        store_bulk_we = 1'b0;

        // Register writes, taken only while idle
        if (idle_wr) begin
            if (reg_addr == REG_EE_ADDR) begin
                d.ee_addr = reg_wdata;
            end else if (reg_addr == REG_EE_DATA) begin
                d.ee_data = reg_wdata;
            end else if (reg_addr == REG_EE_CMD) begin
                d.armed = (reg_wdata == CMD_ARM);
                if (dec_accept) begin
                    d.busy     = 1'b1;
                    d.op       = dec_op;
                    timer_load = 1'b1;
                    timer_val  = (dec_op == OP_UPDATE) ? WAIT_W'(UPDATE_CYCLES - 1)
                                                       : WAIT_W'(BYTE_CYCLES - 1);
                end
            end else if (reg_addr == REG_CTRL) begin
                d.no_refresh = reg_wdata[NOREFRESH_BIT];
            end else if (mir_hit) begin
                d.mirror[mir_idx[$clog2(MIRROR_COUNT+1)-1:0]] = reg_wdata;
            end
        end

        // Reload strobe, lower priority than a command in the same cycle
        if (!q.busy && !d.busy && refresh_tick && !q.no_refresh) begin
            d.busy     = 1'b1;
            d.op       = OP_REFRESH;
            timer_load = 1'b1;
            timer_val  = WAIT_W'(BYTE_CYCLES - 1);
        end

        // Completion: effect lands on the edge that drops busy
        if (q.busy && timer_zero) begin
            d.busy = 1'b0;
            case (q.op)
                OP_READ:    d.ee_data = store_rdata;
                OP_WRITE:   store_we = 1'b1;
                OP_UPDATE:  store_bulk_we = 1'b1;
                OP_REFRESH: begin
                    for (int i = 0; i < MIRROR_COUNT; i++) begin
                        d.mirror[i] = store_image[i];
                    end
                end
                default: d.busy = 1'b0;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q            <= '0;
            q.busy       <= 1'b1;
            q.op         <= OP_REFRESH;
        end else begin
            q <= d;
        end
    end

    // Read-back mux
    always_comb begin
        reg_rdata = 8'h00;
        if (reg_addr == REG_EE_ADDR) begin
            reg_rdata = q.ee_addr;
        end else if (reg_addr == REG_EE_DATA) begin
            reg_rdata = q.ee_data;
        end else if (reg_addr == REG_STATUS) begin
            reg_rdata[BUSY_BIT] = q.busy;
        end else if (reg_addr == REG_CTRL) begin
            reg_rdata[NOREFRESH_BIT] = q.no_refresh;
        end else if (mir_hit) begin
            reg_rdata = q.mirror[mir_idx[$clog2(MIRROR_COUNT+1)-1:0]];
        end
    end

    assign busy = q.busy;

    // R4: busy cannot fall before the wait count has run out
    a_r4_busy_held: assert property (@(posedge clk) disable iff (!rst_n)
        (q.busy && !timer_zero) |=> q.busy);

    // R3: a command start needs an arming write before it
    a_r3_armed_start: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(q.busy) && q.op != OP_REFRESH) |-> $past(q.armed));

    // R8: byte commands only start with an address inside the store
    a_r8_addr_in_range: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(q.busy) && (q.op == OP_READ || q.op == OP_WRITE)) |-> (q.ee_addr < 8'(STORE_DEPTH)));

    // R9: store address register holds while busy
    a_r9_addr_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (q.busy && reg_we && reg_addr == REG_EE_ADDR) |=> $stable(q.ee_addr));

    // R10: a tick with reload suspended starts nothing
    a_r10_tick_suspended: assert property (@(posedge clk) disable iff (!rst_n)
        (!q.busy && q.no_refresh && refresh_tick && !(reg_we && reg_addr == REG_EE_CMD))
            |=> !q.busy);

endmodule

// File: tb/ee_cmd_engine_test.sv
module ee_cmd_engine_test;

    localparam int BYTE_C   = 8;
    localparam int UPDATE_C = 40;
    localparam int DEPTH    = 56;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       reg_we = 1'b0;
    logic [7:0] reg_addr = 8'h00;
    logic [7:0] reg_wdata = 8'h00;
    logic [7:0] reg_rdata;
    logic       refresh_tick = 1'b0;
    logic       busy;

    int n_checks = 0;
    int n_fails  = 0;
    logic [7:0] exp_store [DEPTH];

    always #10 clk = ~clk;

    ee_cmd_engine #(
        .BYTE_CYCLES   (BYTE_C),
        .UPDATE_CYCLES (UPDATE_C),
        .STORE_DEPTH   (DEPTH),
        .MIRROR_BASE   (53),
        .MIRROR_COUNT  (3)
    ) uut (
        .clk          (clk),
        .rst_n        (rst_n),
        .reg_we       (reg_we),
        .reg_addr     (reg_addr),
        .reg_wdata    (reg_wdata),
        .reg_rdata    (reg_rdata),
        .refresh_tick (refresh_tick),
        .busy         (busy)
    );

    task automatic check(input string tag, input int act, input int exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [7:0] v);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = a; reg_wdata = v;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [7:0] v);
        reg_addr = a;
        #1;
        v = reg_rdata;
    endtask

    task automatic busy_len(output int n);
        n = 0;
        while (busy && n < 1000) begin
            n++;
            @(negedge clk);
        end
    endtask

    task automatic tick_once();
        @(negedge clk);
        refresh_tick = 1'b1;
        @(negedge clk);
        refresh_tick = 1'b0;
    endtask

    task automatic t_reset();
        logic [7:0] v;
        int n;
        rd(8'h0E, v);
        check("R2 status busy after reset", v, 8'h80);
        busy_len(n);
        check("R1 reset reload length", n, BYTE_C);
        rd(8'h35, v); check("R1 mirror 0x35", v, 8'h90);
        rd(8'h36, v); check("R1 mirror 0x36", v, 8'h93);
        rd(8'h37, v); check("R1 mirror 0x37", v, 8'h92);
    endtask

    task automatic t_regs();
        logic [7:0] v;
        wr(8'h25, 8'h07); rd(8'h25, v); check("R2 address readback", v, 8'h07);
        wr(8'h26, 8'h3C); rd(8'h26, v); check("R2 data readback", v, 8'h3C);
        wr(8'h0F, 8'hFF); rd(8'h0F, v); check("R2 control bit3 only", v, 8'h08);
        wr(8'h0F, 8'h00); rd(8'h0F, v); check("R2 control cleared", v, 8'h00);
        rd(8'h0E, v); check("R2 status idle", v, 8'h00);
    endtask

    task automatic t_read_cmd();
        logic [7:0] v;
        int n;
        wr(8'h27, 8'h00); wr(8'h27, 8'h22);
        busy_len(n);
        check("R4 read busy length", n, BYTE_C);
        rd(8'h26, v); check("R4 read result", v, exp_store[7]);
    endtask

    task automatic t_write_cmd();
        logic [7:0] v;
        int n;
        wr(8'h25, 8'h10); wr(8'h26, 8'h5E);
        wr(8'h27, 8'h00); wr(8'h27, 8'h21);
        busy_len(n);
        check("R5 write busy length", n, BYTE_C);
        exp_store[16] = 8'h5E;
        wr(8'h26, 8'h00);
        wr(8'h27, 8'h00); wr(8'h27, 8'h22);
        busy_len(n);
        rd(8'h26, v); check("R5 written byte read back", v, 8'h5E);
    endtask

    task automatic t_unarmed();
        logic [7:0] v;
        wr(8'h27, 8'h22);
        check("R3 unarmed command ignored", busy, 0);
        wr(8'h27, 8'h00); wr(8'h25, 8'h07); wr(8'h27, 8'h22);
        check("R3 arm survives other register writes", busy, 1);
        while (busy) @(negedge clk);
        rd(8'h26, v); check("R3 armed read result", v, exp_store[7]);
    endtask

    task automatic t_unknown();
        wr(8'h27, 8'h00); wr(8'h27, 8'h33);
        check("R7 unknown code ignored", busy, 0);
        wr(8'h27, 8'h22);
        check("R7 arm consumed by unknown code", busy, 0);
    endtask

    task automatic t_range();
        logic [7:0] v;
        wr(8'h26, 8'h44);
        wr(8'h25, 8'h38);
        wr(8'h27, 8'h00); wr(8'h27, 8'h22);
        check("R8 read beyond store ignored", busy, 0);
        wr(8'h27, 8'h00); wr(8'h27, 8'h21);
        check("R8 write beyond store ignored", busy, 0);
        rd(8'h26, v); check("R8 data unchanged", v, 8'h44);
    endtask

    task automatic t_update();
        logic [7:0] v;
        int n;
        wr(8'h0F, 8'h08);
        wr(8'h35, 8'h11); wr(8'h36, 8'h22); wr(8'h37, 8'h33);
        wr(8'h27, 8'h00); wr(8'h27, 8'h11);
        busy_len(n);
        check("R6 update busy length", n, UPDATE_C);
        exp_store[53] = 8'h11; exp_store[54] = 8'h22; exp_store[55] = 8'h33;
        for (int i = 53; i < 56; i++) begin
            wr(8'h25, 8'(i));
            wr(8'h27, 8'h00); wr(8'h27, 8'h22);
            busy_len(n);
            rd(8'h26, v); check("R6 store byte after update", v, exp_store[i]);
        end
    endtask

    task automatic t_busy_ignore();
        logic [7:0] v;
        int n;
        wr(8'h25, 8'h11); wr(8'h26, 8'h6B);
        wr(8'h27, 8'h00); wr(8'h27, 8'h21);
        wr(8'h27, 8'h00);
        wr(8'h26, 8'h77);
        wr(8'h35, 8'hEE);
        wr(8'h25, 8'h01);
        busy_len(n);
        exp_store[17] = 8'h6B;
        rd(8'h25, v); check("R9 address held while busy", v, 8'h11);
        rd(8'h26, v); check("R9 data held while busy", v, 8'h6B);
        rd(8'h35, v); check("R9 mirror held while busy", v, 8'h11);
        wr(8'h27, 8'h22);
        check("R9 arm during busy ignored", busy, 0);
    endtask

    task automatic t_refresh();
        logic [7:0] v;
        int n;
        tick_once();
        check("R10 tick ignored when suspended", busy, 0);
        rd(8'h36, v); check("R10 mirror kept when suspended", v, 8'h22);
        wr(8'h0F, 8'h00);
        wr(8'h36, 8'h99);
        tick_once();
        busy_len(n);
        check("R10 reload busy length", n, BYTE_C);
        rd(8'h36, v); check("R10 mirror reloaded", v, exp_store[54]);
    endtask

    task automatic t_collide();
        logic [7:0] v;
        int n;
        wr(8'h35, 8'h5A);
        wr(8'h25, 8'h10);
        wr(8'h27, 8'h00);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = 8'h27; reg_wdata = 8'h22; refresh_tick = 1'b1;
        @(negedge clk);
        reg_we = 1'b0; refresh_tick = 1'b0;
        busy_len(n);
        check("R11 command length wins", n, BYTE_C);
        rd(8'h26, v); check("R11 command result", v, exp_store[16]);
        rd(8'h35, v); check("R11 tick dropped, mirror kept", v, 8'h5A);
        repeat (3) @(negedge clk);
        check("R11 no deferred reload", busy, 0);
    endtask

    initial begin
        for (int i = 0; i < DEPTH; i++) exp_store[i] = 8'(i) ^ 8'hA5;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_regs();
        t_read_cmd();
        t_write_cmd();
        t_unarmed();
        t_unknown();
        t_range();
        t_update();
        t_busy_ignore();
        t_refresh();
        t_collide();
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_checks++;
        n_fails++;
        $display("FAIL watchdog expired actual=%0h expected=%0h", 1, 0);
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
        $finish;
    end

endmodule